// File: doc/BRIEF.md
# Two-Cell Battery Protector Delay Controller

This block is the timing core of a protector for a pack of two cells in series. Comparators outside the block turn cell and current readings into logic flags. This block turns each flag into a delayed decision that drives two logic-level enables: one for the charge switch and one for the discharge switch. All delays are counts of a slow tick of about 4 kHz. The tick arrives as a one-cycle enable on the system clock. There is no separate oscillator for each delay.

The charge path covers three things. It has an overcharge detection delay and an alarm-release delay that restores charging. A low-cell flag forces charging off at once, which stops a shorted (0 V) cell from being charged. The discharge path has two overcurrent levels that share one running count. The count starts when the level-1 flag first rises. Level 1 trips when the count reaches its delay. Level 2 trips as soon as its flag is high and the same count has reached the shorter level-2 delay. A test-mode input shortens only the overcharge delay and the alarm-release delay, by a factor of 128.

Top module: `cellguard_delay_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, chg_en and dis_en are both 1 and all delay counts are zero.
- R2: Flag and test inputs have an effect only on cycles with tick_en = 1. chg_en and dis_en change only on the clock edge that ends a tick cycle.
- R3: chg_en goes to 0 at the end of the tick on which oc_flag has been 1 for OC_DLY consecutive ticks. Any tick with oc_flag = 0 restarts that count.
- R4: While charging is blocked by overcharge, chg_en returns to 1 after ALM_DLY consecutive ticks with rel_flag = 1, provided low_flag is 0. A tick with rel_flag = 0 restarts the count.
- R5: With test_mode = 1, the overcharge and alarm-release delays become the normal value shifted right by 7 bits, with a floor of 1 tick. With the default values these are 4 ticks and 1 tick.
- R6: test_mode has no effect on either overcurrent delay.
- R7: dis_en goes to 0 at the end of the tick on which ioc1_flag has been 1 for I1_DLY consecutive ticks (default 40).
- R8: The level-2 decision uses the level-1 count. On a tick with ioc1_flag = 1 and ioc2_flag = 1, dis_en goes to 0 if the count, including that tick, is at least I2_DLY (default 10). If level 2 rises late, this gives a turn-off time between 0 and I2_DLY ticks.
- R9: A tick with ioc1_flag = 0 before a trip clears the shared count. This cancels both the level-1 and the level-2 decision.
- R10: After an overcurrent trip, dis_en returns to 1 at the end of the first tick on which both ioc1_flag and ioc2_flag are 0.
- R11: A tick with low_flag = 1 makes chg_en 0 at the end of that tick. A tick with low_flag = 0 lifts this block. low_flag never affects dis_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | One-cycle enable at the slow delay tick rate |
| test_mode | input | 1 | 1 shortens the overcharge and alarm-release delays |
| oc_flag | input | 1 | Overcharge comparator flag |
| rel_flag | input | 1 | Overcharge alarm-release comparator flag |
| ioc1_flag | input | 1 | Discharge overcurrent level-1 flag |
| ioc2_flag | input | 1 | Discharge overcurrent level-2 flag |
| low_flag | input | 1 | Cell voltage at or below the 0 V charge inhibit threshold |
| chg_en | output | 1 | Charge switch enable, 1 = on |
| dis_en | output | 1 | Discharge switch enable, 1 = on |

## Verification
Two expiries can land on the same tick: the overcharge delay on the charge side and the level-2 overcurrent trip on the discharge side. The bench holds the overcharge flag for 502 ticks. It then raises both overcurrent flags, so that the overcharge count and the shared overcurrent count (10 ticks) both expire on the same tick. After nine ticks both enables must still be 1. After the tenth tick both must be 0, which shows that neither path holds back or masks the other. A second overlap is also judged: a low-cell block lands while overcurrent counting is live, and dis_en must stay at 1 throughout.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  // Number of bits the test mode shifts the selected delays right.
  localparam int unsigned TEST_SHIFT = 7;

  // Shortened test-mode count, never less than one tick.
  function automatic int unsigned fast_count(input int unsigned normal);
    int unsigned shifted;
    shifted = normal >> TEST_SHIFT;
    return (shifted == 0) ? 1 : shifted;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Charge-side state.
  typedef enum logic {
    CHG_ALLOW = 1'b0,
    CHG_BLOCK = 1'b1
  } chg_state_e;

endpackage

// File: rtl/bpd_tick_counter.sv
module bpd_tick_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_inc
);

  logic [CW-1:0] cnt_d;

  // Saturating increment: the value the count takes if this tick is counted.
  always_comb begin
    if (cnt_q == {CW{1'b1}}) begin
      cnt_inc = cnt_q;
    end else begin
      cnt_inc = cnt_q + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) begin
      cnt_d = run ? cnt_inc : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bpd_charge_ctrl.sv
module bpd_charge_ctrl
  import bpd_pkg::*;
#(
  parameter int unsigned CW       = 10,
  parameter int unsigned OC_NORM  = 512,
  parameter int unsigned ALM_NORM = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic test_mode,
  input  logic oc_flag,
  input  logic rel_flag,
  input  logic low_flag,
  output logic chg_en
);

  localparam int unsigned OC_FAST  = fast_count(OC_NORM);
  localparam int unsigned ALM_FAST = fast_count(ALM_NORM);
  localparam logic [CW-1:0] OC_N_L  = CW'(OC_NORM);
  localparam logic [CW-1:0] OC_T_L  = CW'(OC_FAST);
  localparam logic [CW-1:0] ALM_N_L = CW'(ALM_NORM);
  localparam logic [CW-1:0] ALM_T_L = CW'(ALM_FAST);

  chg_state_e    state_q, state_d;
  logic          low_q, low_d;
  logic          oc_run, alm_run;
  logic [CW-1:0] oc_cnt, oc_inc, alm_cnt, alm_inc;
  logic [CW-1:0] oc_lim, alm_lim;
  logic          oc_hit, alm_hit;

  assign oc_lim  = test_mode ? OC_T_L  : OC_N_L;
  assign alm_lim = test_mode ? ALM_T_L : ALM_N_L;

  assign oc_run  = oc_flag && (state_q == CHG_ALLOW);
  assign alm_run = rel_flag && (state_q == CHG_BLOCK);

  bpd_tick_counter #(.CW(CW)) u_oc_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(oc_run),
    .cnt_q(oc_cnt), .cnt_inc(oc_inc)
  );

  bpd_tick_counter #(.CW(CW)) u_alm_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(alm_run),
    .cnt_q(alm_cnt), .cnt_inc(alm_inc)
  );

  assign oc_hit  = tick_en && oc_run  && (oc_inc  >= oc_lim);
  assign alm_hit = tick_en && alm_run && (alm_inc >= alm_lim);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CHG_ALLOW: if (oc_hit)  state_d = CHG_BLOCK;
      CHG_BLOCK: if (alm_hit) state_d = CHG_ALLOW;
      default:                state_d = CHG_ALLOW;
    endcase
  end

  always_comb begin
    low_d = low_q;
    if (tick_en) begin
      low_d = low_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CHG_ALLOW;
      low_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      low_q   <= low_d;
    end
  end

  assign chg_en = (state_q == CHG_ALLOW) && !low_q;

endmodule

// File: rtl/bpd_discharge_ctrl.sv
module bpd_discharge_ctrl #(
  parameter int unsigned CW     = 10,
  parameter int unsigned L1_DLY = 40,
  parameter int unsigned L2_DLY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic ioc1_flag,
  input  logic ioc2_flag,
  output logic dis_en
);

  localparam logic [CW-1:0] L1_L = CW'(L1_DLY);
  localparam logic [CW-1:0] L2_L = CW'(L2_DLY);

  logic          trip_q, trip_d;
  logic          run;
  logic [CW-1:0] cnt, inc;
  logic          hit_l1, hit_l2, release_ok;

  // One shared count: it starts when level 1 rises and serves both levels.
  assign run = ioc1_flag && !trip_q;

  bpd_tick_counter #(.CW(CW)) u_shared_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
    .cnt_q(cnt), .cnt_inc(inc)
  );

  assign hit_l1     = tick_en && run && (inc >= L1_L);
  assign hit_l2     = tick_en && run && ioc2_flag && (inc >= L2_L);
  assign release_ok = tick_en && trip_q && !ioc1_flag && !ioc2_flag;

  always_comb begin
    trip_d = trip_q;
    if (hit_l1 || hit_l2) begin
      trip_d = 1'b1;
    end else if (release_ok) begin
      trip_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
    end else begin
      trip_q <= trip_d;
    end
  end

  assign dis_en = !trip_q;

endmodule

// File: rtl/cellguard_delay_ctrl.sv
module cellguard_delay_ctrl
  import bpd_pkg::*;
#(
  parameter int unsigned OC_DLY  = 512,
  parameter int unsigned ALM_DLY = 100,
  parameter int unsigned I1_DLY  = 40,
  parameter int unsigned I2_DLY  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic test_mode,
  input  logic oc_flag,
  input  logic rel_flag,
  input  logic ioc1_flag,
  input  logic ioc2_flag,
  input  logic low_flag,
  output logic chg_en,
  output logic dis_en
);

  localparam int unsigned MAX_DLY = max3(OC_DLY, ALM_DLY, I1_DLY);
  localparam int unsigned CW      = $clog2(MAX_DLY + 1);

  bpd_charge_ctrl #(
    .CW(CW), .OC_NORM(OC_DLY), .ALM_NORM(ALM_DLY)
  ) u_charge (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .test_mode(test_mode),
    .oc_flag(oc_flag), .rel_flag(rel_flag), .low_flag(low_flag),
    .chg_en(chg_en)
  );

  bpd_discharge_ctrl #(
    .CW(CW), .L1_DLY(I1_DLY), .L2_DLY(I2_DLY)
  ) u_discharge (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .ioc1_flag(ioc1_flag), .ioc2_flag(ioc2_flag),
    .dis_en(dis_en)
  );

endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
  parameter int unsigned I1_DLY = 40,
  parameter int unsigned I2_DLY = 10
) (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic oc_flag,
  input logic ioc1_flag,
  input logic ioc2_flag,
  input logic low_flag,
  input logic chg_en,
  input logic dis_en
);

  // Own count of consecutive level-1 ticks while discharge is enabled.
  logic [15:0] l1_ticks;
  logic [15:0] l1_next;

  assign l1_next = l1_ticks + 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_ticks <= '0;
    end else if (tick_en) begin
      l1_ticks <= (ioc1_flag && dis_en) ? l1_next : '0;
    end
  end

  // R1: both enables on while in reset
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      a_r1_reset_on: assert (chg_en && dis_en);
    end
  end

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(chg_en) && $stable(dis_en)));

  a_r3_no_drop_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && chg_en && !oc_flag && !low_flag) |=> chg_en);

  a_r7_l1_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && dis_en && ioc1_flag && !ioc2_flag && (l1_next < 16'(I1_DLY))) |=> dis_en);

  a_r8_l2_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && dis_en && ioc1_flag && ioc2_flag && (l1_next >= 16'(I2_DLY))) |=> !dis_en);

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ioc1_flag && !ioc2_flag) |=> dis_en);

  a_r11_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && low_flag) |=> !chg_en);

endmodule

bind cellguard_delay_ctrl bpd_checker #(
  .I1_DLY(I1_DLY), .I2_DLY(I2_DLY)
) u_bpd_checker (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .oc_flag(oc_flag),
  .ioc1_flag(ioc1_flag), .ioc2_flag(ioc2_flag), .low_flag(low_flag),
  .chg_en(chg_en), .dis_en(dis_en)
);

// File: tb/test_cellguard_delay_ctrl.sv
module test_cellguard_delay_ctrl;

  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, tick_en, test_mode;
  logic oc_flag, rel_flag, ioc1_flag, ioc2_flag, low_flag;
  logic chg_en, dis_en;
  int   checks, errors;

  cellguard_delay_ctrl i_cellguard_delay_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .test_mode(test_mode),
    .oc_flag(oc_flag), .rel_flag(rel_flag), .ioc1_flag(ioc1_flag),
    .ioc2_flag(ioc2_flag), .low_flag(low_flag),
    .chg_en(chg_en), .dis_en(dis_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  // Each tick is one cycle with tick_en high, then one cycle without.
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
  endtask

  task automatic idle_flags;
    oc_flag = 0; rel_flag = 0; ioc1_flag = 0; ioc2_flag = 0; low_flag = 0;
    test_mode = 0;
  endtask

  task automatic t_reset;
    idle_flags();
    tick_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 chg_en in reset", chg_en, 1'b1);
    chk("R1 dis_en in reset", dis_en, 1'b1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 chg_en after reset", chg_en, 1'b1);
  endtask

  task automatic t_overcharge;
    oc_flag = 1;
    ticks(300);
    oc_flag = 0;
    ticks(1);
    oc_flag = 1;
    ticks(300);
    chk("R3 restart after gap", chg_en, 1'b1);
    ticks(211);
    chk("R3 one tick before expiry", chg_en, 1'b1);
    ticks(1);
    chk("R3 overcharge expiry", chg_en, 1'b0);
    oc_flag = 0;
    rel_flag = 1;
    ticks(50);
    rel_flag = 0;
    ticks(1);
    rel_flag = 1;
    ticks(99);
    chk("R4 release not early", chg_en, 1'b0);
    ticks(1);
    chk("R4 release expiry", chg_en, 1'b1);
    rel_flag = 0;
  endtask

  task automatic t_test_mode_charge;
    test_mode = 1;
    oc_flag = 1;
    ticks(3);
    chk("R5 test overcharge not early", chg_en, 1'b1);
    ticks(1);
    chk("R5 test overcharge at 4", chg_en, 1'b0);
    oc_flag = 0;
    rel_flag = 1;
    ticks(1);
    chk("R5 test release floor 1", chg_en, 1'b1);
    rel_flag = 0;
    test_mode = 0;
  endtask

  task automatic t_level1;
    ioc1_flag = 1;
    ticks(39);
    chk("R7 level1 not early", dis_en, 1'b1);
    ticks(1);
    chk("R7 level1 expiry", dis_en, 1'b0);
    ioc1_flag = 0;
    ticks(1);
    chk("R10 release on clear tick", dis_en, 1'b1);
  endtask

  task automatic t_test_mode_oc;
    test_mode = 1;
    ioc1_flag = 1;
    ticks(39);
    chk("R6 test mode keeps level1 delay", dis_en, 1'b1);
    ticks(1);
    chk("R6 level1 expiry in test mode", dis_en, 1'b0);
    ioc1_flag = 0;
    ticks(1);
    test_mode = 0;
  endtask

  task automatic t_level2;
    ioc1_flag = 1;
    ticks(5);
    ioc2_flag = 1;
    ticks(4);
    chk("R8 level2 shared count not early", dis_en, 1'b1);
    ticks(1);
    chk("R8 level2 at shared count 10", dis_en, 1'b0);
    ioc2_flag = 0;
    ticks(2);
    chk("R10 still held with level1 high", dis_en, 1'b0);
    ioc1_flag = 0;
    ticks(1);
    ioc1_flag = 1;
    ticks(20);
    ioc2_flag = 1;
    ticks(1);
    chk("R8 late level2 immediate trip", dis_en, 1'b0);
    ioc1_flag = 0; ioc2_flag = 0;
    ticks(1);
    chk("R10 release after late trip", dis_en, 1'b1);
  endtask

  task automatic t_cancel;
    ioc1_flag = 1;
    ticks(30);
    ioc1_flag = 0;
    ticks(1);
    ioc1_flag = 1;
    ticks(30);
    chk("R9 level1 cancel", dis_en, 1'b1);
    ioc1_flag = 0;
    ticks(1);
    ioc1_flag = 1;
    ticks(8);
    ioc1_flag = 0;
    ticks(1);
    ioc1_flag = 1; ioc2_flag = 1;
    ticks(9);
    chk("R9 level2 cancel", dis_en, 1'b1);
    ioc1_flag = 0; ioc2_flag = 0;
    ticks(1);
  endtask

  task automatic t_low_cell;
    ioc1_flag = 1;
    low_flag = 1;
    ticks(1);
    chk("R11 low cell blocks charge", chg_en, 1'b0);
    chk("R11 low cell leaves discharge", dis_en, 1'b1);
    low_flag = 0;
    ticks(1);
    chk("R11 low cell lifted", chg_en, 1'b1);
    ioc1_flag = 0;
    ticks(1);
  endtask

  task automatic t_no_tick;
    oc_flag = 1;
    low_flag = 1;
    ioc1_flag = 1;
    repeat (3000) @(negedge clk);
    chk("R2 no tick charge unchanged", chg_en, 1'b1);
    chk("R2 no tick discharge unchanged", dis_en, 1'b1);
    low_flag = 0;
    ioc1_flag = 0;
    oc_flag = 0;
    ticks(1);
    oc_flag = 1;
    ticks(511);
    chk("R2 no hidden counting", chg_en, 1'b1);
    oc_flag = 0;
    ticks(1);
  endtask

  task automatic t_same_tick;
    oc_flag = 1;
    ticks(502);
    ioc1_flag = 1; ioc2_flag = 1;
    ticks(9);
    chk("R3 charge before joint expiry", chg_en, 1'b1);
    chk("R8 discharge before joint expiry", dis_en, 1'b1);
    ticks(1);
    chk("R3 joint expiry charge", chg_en, 1'b0);
    chk("R8 joint expiry discharge", dis_en, 1'b0);
    oc_flag = 0; ioc1_flag = 0; ioc2_flag = 0;
    rel_flag = 1;
    ticks(100);
    chk("R4 joint cleanup charge", chg_en, 1'b1);
    chk("R10 joint cleanup discharge", dis_en, 1'b1);
    rel_flag = 0;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 0;
    t_reset();
    t_overcharge();
    t_test_mode_charge();
    t_level1();
    t_test_mode_oc();
    t_level2();
    t_cancel();
    t_low_cell();
    t_no_tick();
    t_same_tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule